// File: doc/BRIEF.md
# DDR SDRAM Command Protocol Checker

This block sits beside a DDR SDRAM device and watches the command pins on every rising clock edge. It turns each cycle's pin pattern into a named command and keeps a small model of the device. For each bank it records whether a row is open and how many cycles must pass before the bank will accept another command. For the device as a whole it records the power state: up, self refresh, precharge power-down or active power-down.

Each decoded command is reported one cycle after it is sampled. When a command breaks a protocol rule, a one-cycle violation pulse is raised together with a code that names the rule. A command that breaks a rule is treated as dropped, so the model does not change. The precharge time, the write recovery time and the burst length are static inputs. They set the lockout windows that follow an explicit precharge and the windows that follow a read or write with auto-precharge.

Top module: `ddr_cmd_checker`

## Requirements
- R1: With both CKE samples high and chip select low, {ras_n,cas_n,we_n} decodes as follows, with the reported code in brackets: 011 activate (4), 101 read (5, or 6 with a10_ap high), 100 write (7, or 8 with a10_ap high), 010 precharge (9, or 10 with a10_ap high), 110 burst stop (11), 001 auto refresh (12) and 111 no operation (1). cmd_o shows the code one cycle after the command is sampled.
- R2: With both CKE samples high and chip select high, the cycle decodes as deselect (0) and has no effect whatever the other pins are. The pattern 000 decodes as mode register set (2) when ba[0] is 0 and as extended mode register set (3) when ba[0] is 1.
- R3: An activate sets the addressed bank's bit in bank_active_o. An activate to a bank that is already active is a violation with code 1.
- R4: A read or write (code 5, 6, 7 or 8) to an idle bank is a violation with code 2. A read or write with a10_ap low leaves the bank active.
- R5: A read with auto-precharge at cycle n closes the bank. The bank then accepts no command until cycle n + BL/2 + tRP. A write with auto-precharge at cycle n closes the bank and locks it until cycle n + BL/2 + 1 + tWR + tRP. An earlier activate, read, write or precharge to that bank is a violation with code 3.
- R6: A precharge with a10_ap low closes only the bank on ba. With a10_ap high it closes every bank and ba is ignored. A bank locks for tRP cycles after any precharge (code 3), and a precharge-all while any bank is locked is code 3.
- R7: A mode register set or extended mode register set while any bank is active or still locked is a violation with code 4.
- R8: CKE going high to low with the auto refresh pattern enters self refresh (pwr_o 1). CKE going low to high with a deselect or no-operation pattern returns to up (pwr_o 0).
- R9: CKE going high to low with a deselect or no-operation pattern enters precharge power-down (pwr_o 2) when every bank is idle, and active power-down (pwr_o 3) otherwise.
- R10: Code 5 is raised when the CKE samples do not match the power state: a high previous sample while not up, or a low previous sample while up. Otherwise, a CKE edge with any pattern not allowed for that edge decodes as 17 and is code 6. CKE held low decodes as 16.
- R11: viol_o is high for exactly the cycle that reports an offending command, with viol_code_o non-zero. A violating command changes neither bank_active_o nor pwr_o.
- R12: cfg_bl selects burst length 2, 4 or 8 with the values 0, 1 and 2, and the value 3 also means 8. This changes BL/2 in the auto-precharge windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_trp | input | 4 | Precharge time in cycles |
| cfg_twr | input | 4 | Write recovery time in cycles |
| cfg_bl | input | 2 | Burst length select |
| cke_last | input | 1 | Clock enable sampled one cycle earlier |
| cke_now | input | 1 | Clock enable this cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| a10_ap | input | 1 | Auto-precharge / all-banks bit |
| ba | input | 2 | Bank address |
| cmd_o | output | 5 | Decoded command code |
| viol_o | output | 1 | Violation pulse |
| viol_code_o | output | 3 | Rule broken (0 when none) |
| bank_active_o | output | 4 | One bit per bank, set while a row is open |
| pwr_o | output | 2 | 0 up, 1 self refresh, 2 precharge power-down, 3 active power-down |

## Verification
The bench probes the auto-precharge windows at both edges: one cycle before the window ends, where the command must be rejected, and on the closing cycle, where it must be accepted. It does this for all three burst lengths, so a design that is off by one in its countdown flags a legal command or lets an early one through. It issues a mode register set right after a precharge and again once tRP has passed, and it enters power-down once with all banks idle and once with a row open. A design that ignores the lockouts or picks the power-down type from stale state then reports the wrong code or the wrong pwr_o. Malformed CKE edges and a command driven while powered down must each give their own code and leave the state untouched. A long stretch of pseudo-random pins is also compared cycle by cycle against a behavioural model.

// File: rtl/ddr_chk_pkg.sv
package ddr_chk_pkg;

  typedef enum logic [4:0] {
    C_DESEL   = 5'd0,
    C_NOP     = 5'd1,
    C_MRS     = 5'd2,
    C_EMRS    = 5'd3,
    C_ACT     = 5'd4,
    C_RD      = 5'd5,
    C_RDA     = 5'd6,
    C_WR      = 5'd7,
    C_WRA     = 5'd8,
    C_PRE     = 5'd9,
    C_PREA    = 5'd10,
    C_BST     = 5'd11,
    C_REF     = 5'd12,
    C_SREF_EN = 5'd13,
    C_PD_EN   = 5'd14,
    C_EXIT    = 5'd15,
    C_CKE_LOW = 5'd16,
    C_ILLEGAL = 5'd17
  } cmd_e;

  typedef enum logic [2:0] {
    V_NONE     = 3'd0,
    V_ACT_OPEN = 3'd1,
    V_RW_IDLE  = 3'd2,
    V_LOCKOUT  = 3'd3,
    V_MRS_BUSY = 3'd4,
    V_PWR_SEQ  = 3'd5,
    V_CKE_CMD  = 3'd6
  } viol_e;

  typedef enum logic [1:0] {
    PS_UP   = 2'd0,
    PS_SREF = 2'd1,
    PS_PPD  = 2'd2,
    PS_APD  = 2'd3
  } pwr_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_chk_pkg::*;
(
  input  logic cke_last,
  input  logic cke_now,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10_ap,
  input  logic ba_lsb,
  output cmd_e cmd
);

  logic [2:0] rcw;
  logic       quiet_pat;
  logic       refresh_pat;

  assign rcw         = {ras_n, cas_n, we_n};
  assign quiet_pat   = cs_n | (rcw == 3'b111);
  assign refresh_pat = !cs_n && (rcw == 3'b001);

  always_comb begin
    cmd = C_DESEL;
    case ({cke_last, cke_now})
      2'b11: begin
        if (cs_n) begin
          cmd = C_DESEL;
        end else begin
          case (rcw)
            3'b000:  cmd = ba_lsb ? C_EMRS : C_MRS;
            3'b011:  cmd = C_ACT;
            3'b101:  cmd = a10_ap ? C_RDA : C_RD;
            3'b100:  cmd = a10_ap ? C_WRA : C_WR;
            3'b010:  cmd = a10_ap ? C_PREA : C_PRE;
            3'b110:  cmd = C_BST;
            3'b001:  cmd = C_REF;
            default: cmd = C_NOP;
          endcase
        end
      end
      2'b10: begin
        if (quiet_pat)        cmd = C_PD_EN;
        else if (refresh_pat) cmd = C_SREF_EN;
        else                  cmd = C_ILLEGAL;
      end
      2'b01:   cmd = quiet_pat ? C_EXIT : C_ILLEGAL;
      default: cmd = C_CKE_LOW;
    endcase
  end

endmodule

// File: rtl/ddr_window_calc.sv
module ddr_window_calc #(
  parameter int TIM_W = 4,
  parameter int CNT_W = TIM_W + 2
) (
  input  logic [TIM_W-1:0] cfg_trp,
  input  logic [TIM_W-1:0] cfg_twr,
  input  logic [1:0]       cfg_bl,
  output logic [CNT_W-1:0] pre_ld,
  output logic [CNT_W-1:0] rda_ld,
  output logic [CNT_W-1:0] wra_ld
);

  localparam int PAD_W = CNT_W - TIM_W;

  logic [CNT_W-1:0] half_bl;
  logic [CNT_W-1:0] trp_x;
  logic [CNT_W-1:0] twr_x;
  logic [CNT_W-1:0] rda_len;
  logic [CNT_W-1:0] wra_len;

  // Counters are loaded with the window length minus one, never below zero.
  function automatic logic [CNT_W-1:0] minus_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  always_comb begin
    case (cfg_bl)
      2'd0:    half_bl = CNT_W'(1);
      2'd1:    half_bl = CNT_W'(2);
      default: half_bl = CNT_W'(4);
    endcase
  end

  assign trp_x   = {{PAD_W{1'b0}}, cfg_trp};
  assign twr_x   = {{PAD_W{1'b0}}, cfg_twr};
  assign rda_len = half_bl + trp_x;
  assign wra_len = half_bl + CNT_W'(1) + twr_x + trp_x;

  assign pre_ld = minus_one(trp_x);
  assign rda_ld = minus_one(rda_len);
  assign wra_ld = minus_one(wra_len);

endmodule

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_i,
  input  logic             close_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             active_o,
  output logic             busy_o
);

  logic             act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    act_d = act_q;
    if (open_i)       act_d = 1'b1;
    else if (close_i) act_d = 1'b0;

    cnt_d = cnt_q;
    if (load_i)             cnt_d = load_val_i;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign active_o = act_q;
  assign busy_o   = (cnt_q != '0);

  // Checker must only open a bank that is idle and out of its lockout.
  p_open_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    open_i |-> (!busy_o && !act_q));

  // A row only opens on an accepted activate.
  p_rise_on_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> $past(open_i));

  // Open and close never target the same bank in one cycle.
  p_open_close_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(open_i && close_i));

endmodule

// File: rtl/ddr_pwr_fsm.sv
module ddr_pwr_fsm
  import ddr_chk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cmd_e cmd_i,
  input  logic legal_i,
  input  logic any_active_i,
  output pwr_e state_o
);

  pwr_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (legal_i) begin
      if (state_q == PS_UP) begin
        if (cmd_i == C_SREF_EN)    state_d = PS_SREF;
        else if (cmd_i == C_PD_EN) state_d = any_active_i ? PS_APD : PS_PPD;
      end else if (cmd_i == C_EXIT) begin
        state_d = PS_UP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_UP;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // Precharge power-down is only entered with every bank idle.
  p_ppd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_PPD && $past(state_q) == PS_UP) |-> !$past(any_active_i));

  // Active power-down is only entered with some row open.
  p_apd_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_APD && $past(state_q) == PS_UP) |-> $past(any_active_i));

  // A clean exit from any low-power state returns to up.
  p_exit_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PS_UP && cmd_i == C_EXIT && legal_i) |=> state_q == PS_UP);

endmodule

// File: rtl/ddr_cmd_checker.sv
module ddr_cmd_checker
  import ddr_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TIM_W     = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [TIM_W-1:0]             cfg_trp,
  input  logic [TIM_W-1:0]             cfg_twr,
  input  logic [1:0]                   cfg_bl,
  input  logic                         cke_last,
  input  logic                         cke_now,
  input  logic                         cs_n,
  input  logic                         ras_n,
  input  logic                         cas_n,
  input  logic                         we_n,
  input  logic                         a10_ap,
  input  logic [$clog2(NUM_BANKS)-1:0] ba,
  output logic [4:0]                   cmd_o,
  output logic                         viol_o,
  output logic [2:0]                   viol_code_o,
  output logic [NUM_BANKS-1:0]         bank_active_o,
  output logic [1:0]                   pwr_o
);

  localparam int CNT_W = TIM_W + 2;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cmd_e             cmd_now;
  pwr_e             pwr_state;
  viol_e            code_d;
  logic [NUM_BANKS-1:0] bank_act;
  logic [NUM_BANKS-1:0] bank_busy;
  logic [NUM_BANKS-1:0] sel;
  logic [NUM_BANKS-1:0] open_v, close_v, load_v;
  logic [CNT_W-1:0]     ld_val;
  logic [CNT_W-1:0]     pre_ld, rda_ld, wra_ld;
  logic                 any_act, any_busy, is_up, legal;

  ddr_cmd_decode u_decode (
    .cke_last (cke_last),
    .cke_now  (cke_now),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .a10_ap   (a10_ap),
    .ba_lsb   (ba[0]),
    .cmd      (cmd_now)
  );

  ddr_window_calc #(.TIM_W(TIM_W), .CNT_W(CNT_W)) u_windows (
    .cfg_trp (cfg_trp),
    .cfg_twr (cfg_twr),
    .cfg_bl  (cfg_bl),
    .pre_ld  (pre_ld),
    .rda_ld  (rda_ld),
    .wra_ld  (wra_ld)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ddr_bank_slot #(.CNT_W(CNT_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .open_i     (open_v[b]),
      .close_i    (close_v[b]),
      .load_i     (load_v[b]),
      .load_val_i (ld_val),
      .active_o   (bank_act[b]),
      .busy_o     (bank_busy[b])
    );
  end

  ddr_pwr_fsm u_pwr (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .cmd_i        (cmd_now),
    .legal_i      (legal),
    .any_active_i (any_act),
    .state_o      (pwr_state)
  );

  assign any_act  = |bank_act;
  assign any_busy = |bank_busy;
  assign is_up    = (pwr_state == PS_UP);
  assign legal    = (code_d == V_NONE);

  always_comb begin
    sel     = '0;
    sel[ba] = 1'b1;
  end

  // Rule check, in priority order: power sequencing, malformed CKE edge,
  // then the per-command bank rules.
  always_comb begin
    code_d = V_NONE;
    if (cke_last && !is_up) begin
      code_d = V_PWR_SEQ;
    end else if (!cke_last && is_up) begin
      code_d = V_PWR_SEQ;
    end else if (cmd_now == C_ILLEGAL) begin
      code_d = V_CKE_CMD;
    end else begin
      case (cmd_now)
        C_ACT: begin
          if (bank_busy[ba])     code_d = V_LOCKOUT;
          else if (bank_act[ba]) code_d = V_ACT_OPEN;
        end
        C_RD, C_RDA, C_WR, C_WRA: begin
          if (bank_busy[ba])      code_d = V_LOCKOUT;
          else if (!bank_act[ba]) code_d = V_RW_IDLE;
        end
        C_PRE: begin
          if (bank_busy[ba]) code_d = V_LOCKOUT;
        end
        C_PREA: begin
          if (any_busy) code_d = V_LOCKOUT;
        end
        C_MRS, C_EMRS: begin
          if (any_act || any_busy) code_d = V_MRS_BUSY;
        end
        default: code_d = V_NONE;
      endcase
    end
  end

  // Bank updates for accepted commands only.
  always_comb begin
    open_v  = '0;
    close_v = '0;
    load_v  = '0;
    ld_val  = pre_ld;
    if (legal) begin
      case (cmd_now)
        C_ACT: open_v = sel;
        C_RDA: begin
          close_v = sel;
          load_v  = sel;
          ld_val  = rda_ld;
        end
        C_WRA: begin
          close_v = sel;
          load_v  = sel;
          ld_val  = wra_ld;
        end
        C_PRE: begin
          close_v = sel;
          load_v  = sel;
        end
        C_PREA: begin
          close_v = '1;
          load_v  = '1;
        end
        default: ;
      endcase
    end
  end

  // Report register.
  cmd_e  cmd_q;
  logic  viol_q;
  viol_e code_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cmd_q  <= C_DESEL;
      viol_q <= 1'b0;
      code_q <= V_NONE;
    end else begin
      cmd_q  <= cmd_now;
      viol_q <= !legal;
      code_q <= code_d;
    end
  end

  assign cmd_o         = cmd_q;
  assign viol_o        = viol_q;
  assign viol_code_o   = code_q;
  assign bank_active_o = bank_act;
  assign pwr_o         = pwr_state;

  // A reported mode register set that passed found every bank idle.
  p_mrs_idle_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((cmd_q == C_MRS || cmd_q == C_EMRS) && !viol_q) |-> bank_act == '0);

  // A malformed CKE edge is always flagged.
  p_bad_edge_flag_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_q == C_ILLEGAL) |-> viol_q);

  // A rejected command leaves the open-row set alone.
  p_hold_on_viol_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    viol_q |-> bank_act == $past(bank_act));

  // A rejected command leaves the power state alone.
  p_pwr_hold_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    viol_q |-> pwr_state == $past(pwr_state));

endmodule

// File: tb/ddr_cmd_checker_tb.sv
`timescale 1ns/1ps
module ddr_cmd_checker_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] cfg_trp, cfg_twr;
  logic [1:0] cfg_bl;
  logic       cke_last, cke_now, cs_n, ras_n, cas_n, we_n, a10_ap;
  logic [1:0] ba;
  logic [4:0] cmd_o;
  logic       viol_o;
  logic [2:0] viol_code_o;
  logic [3:0] bank_active_o;
  logic [1:0] pwr_o;

  always #4 clk = ~clk;

  ddr_cmd_checker dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_trp(cfg_trp), .cfg_twr(cfg_twr), .cfg_bl(cfg_bl),
    .cke_last(cke_last), .cke_now(cke_now), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a10_ap(a10_ap), .ba(ba),
    .cmd_o(cmd_o), .viol_o(viol_o), .viol_code_o(viol_code_o),
    .bank_active_o(bank_active_o), .pwr_o(pwr_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Behavioural reference: open flags, cycle at which each bank is free again.
  bit     m_open[4];
  longint m_free_at[4];
  int     m_pwr;
  longint now_cyc;

  function automatic int ref_decode(bit kl, bit kn, bit cs, bit r, bit c, bit w, bit ap, int b);
    int pat;
    bit quiet;
    pat   = r * 4 + c * 2 + w;
    quiet = cs || (pat == 7);
    if (kl && kn) begin
      if (cs) return 0;
      case (pat)
        0: return (b % 2 == 1) ? 3 : 2;
        3: return 4;
        5: return ap ? 6 : 5;
        4: return ap ? 8 : 7;
        2: return ap ? 10 : 9;
        6: return 11;
        1: return 12;
        default: return 1;
      endcase
    end
    if (kl && !kn) begin
      if (quiet) return 14;
      if (!cs && pat == 1) return 13;
      return 17;
    end
    if (!kl && kn) return quiet ? 15 : 17;
    return 16;
  endfunction

  function automatic bit locked(int b);
    return now_cyc < m_free_at[b];
  endfunction

  function automatic int ref_rule(int cmd, bit kl, int b);
    bit up, any_open, any_lock;
    up = (m_pwr == 0);
    any_open = 0; any_lock = 0;
    for (int i = 0; i < 4; i++) begin
      any_open |= m_open[i];
      any_lock |= locked(i);
    end
    if (kl && !up) return 5;
    if (!kl && up) return 5;
    if (cmd == 17) return 6;
    case (cmd)
      4: return locked(b) ? 3 : (m_open[b] ? 1 : 0);
      5, 6, 7, 8: return locked(b) ? 3 : (!m_open[b] ? 2 : 0);
      9: return locked(b) ? 3 : 0;
      10: return any_lock ? 3 : 0;
      2, 3: return (any_open || any_lock) ? 4 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int half_burst();
    return (cfg_bl == 0) ? 1 : ((cfg_bl == 1) ? 2 : 4);
  endfunction

  task automatic check(string req, int e_cmd, int e_code);
    int e_act;
    e_act = 0;
    for (int i = 0; i < 4; i++) if (m_open[i]) e_act |= (1 << i);
    n_cmp++;
    if (cmd_o !== e_cmd[4:0] || viol_o !== (e_code != 0) || viol_code_o !== e_code[2:0] ||
        bank_active_o !== e_act[3:0] || pwr_o !== m_pwr[1:0]) begin
      n_bad++;
      $display("FAIL %s cyc %0d: got cmd=%0d viol=%0b code=%0d banks=%b pwr=%0d exp cmd=%0d viol=%0b code=%0d banks=%b pwr=%0d",
               req, now_cyc, cmd_o, viol_o, viol_code_o, bank_active_o, pwr_o,
               e_cmd, (e_code != 0), e_code, e_act[3:0], m_pwr);
    end
  endtask

  // One cycle: drive at the falling edge, model at the rising edge, compare at the next falling edge.
  task automatic cyc(bit kl, bit kn, bit cs, bit r, bit c, bit w, bit ap, int b, string req);
    int cmd, code, L;
    bit any_open;
    cke_last = kl; cke_now = kn; cs_n = cs;
    ras_n = r; cas_n = c; we_n = w; a10_ap = ap; ba = b[1:0];
    @(posedge clk);
    cmd  = ref_decode(kl, kn, cs, r, c, w, ap, b);
    code = ref_rule(cmd, kl, b);
    any_open = 0;
    for (int i = 0; i < 4; i++) any_open |= m_open[i];
    if (code == 0) begin
      case (cmd)
        4: m_open[b] = 1;
        6: begin m_open[b] = 0; L = half_burst() + cfg_trp; m_free_at[b] = now_cyc + L; end
        8: begin m_open[b] = 0; L = half_burst() + 1 + cfg_twr + cfg_trp; m_free_at[b] = now_cyc + L; end
        9: begin m_open[b] = 0; m_free_at[b] = now_cyc + cfg_trp; end
        10: for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_free_at[i] = now_cyc + cfg_trp; end
        13: m_pwr = 1;
        14: m_pwr = any_open ? 3 : 2;
        15: m_pwr = 0;
        default: ;
      endcase
    end
    @(negedge clk);
    check(req, cmd, code);
    now_cyc++;
  endtask

  task automatic cmd(bit r, bit c, bit w, bit ap, int b, string req);
    cyc(1, 1, 0, r, c, w, ap, b, req);
  endtask

  task automatic nops(int n, string req);
    for (int i = 0; i < n; i++) cmd(1, 1, 1, 0, 0, req);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got run still going, expected end of stimulus");
    summary();
  end

  initial begin
    bit pk;
    rst_n = 0;
    cfg_trp = 4'd3; cfg_twr = 4'd2; cfg_bl = 2'd1;
    cke_last = 1; cke_now = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; a10_ap = 0; ba = 0;
    for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_free_at[i] = 0; end
    m_pwr = 0; now_cyc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(negedge clk);
    check("R11 reset", 0, 0);

    // R2: deselect with noisy pins; MRS / EMRS by ba[0]
    cyc(1, 1, 1, 0, 0, 0, 1, 2, "R2");
    cmd(0, 0, 0, 0, 0, "R2");
    cmd(0, 0, 0, 0, 1, "R2");
    // R1: burst stop, refresh, nop
    cmd(1, 1, 0, 0, 0, "R1");
    cmd(0, 0, 1, 0, 0, "R1");
    cmd(1, 1, 1, 0, 0, "R1");
    // R3: activate, double activate
    cmd(0, 1, 1, 0, 0, "R3");
    cmd(0, 1, 1, 0, 0, "R3");
    // R4: read open row, write idle bank
    cmd(1, 0, 1, 0, 0, "R4");
    cmd(1, 0, 0, 0, 1, "R4");
    // R5: read auto-precharge, window 2+3=5
    cmd(1, 0, 1, 1, 0, "R5");
    nops(3, "R5");
    cmd(0, 1, 1, 0, 0, "R5");
    cmd(0, 1, 1, 0, 0, "R5");
    // R5: write auto-precharge, window 2+1+2+3=8
    cmd(1, 0, 0, 1, 0, "R5");
    nops(6, "R5");
    cmd(1, 0, 1, 0, 0, "R5");
    cmd(0, 1, 1, 0, 0, "R5");
    // R6: precharge all ignores ba, then tRP lockout
    cmd(0, 1, 1, 0, 1, "R6");
    cmd(0, 1, 1, 0, 2, "R6");
    cmd(0, 1, 0, 1, 3, "R6");
    nops(1, "R6");
    cmd(0, 1, 1, 0, 1, "R6");
    cmd(0, 1, 1, 0, 1, "R6");
    cmd(0, 1, 1, 0, 0, "R6");
    cmd(0, 1, 0, 0, 1, "R6");
    // R7: MRS with open row, right after precharge, then after tRP
    cmd(0, 0, 0, 0, 0, "R7");
    cmd(0, 1, 0, 0, 0, "R7");
    cmd(0, 0, 0, 0, 0, "R7");
    nops(1, "R7");
    cmd(0, 0, 0, 0, 0, "R7");
    // R9: precharge power-down, then active power-down
    cyc(1, 0, 1, 0, 0, 0, 0, 0, "R9");
    cyc(0, 0, 1, 1, 1, 1, 0, 0, "R9");
    cyc(0, 1, 1, 0, 1, 0, 0, 0, "R9");
    cmd(0, 1, 1, 0, 2, "R9");
    cyc(1, 0, 0, 1, 1, 1, 0, 0, "R9");
    cyc(0, 0, 0, 1, 1, 1, 0, 0, "R9");
    cyc(0, 1, 0, 1, 1, 1, 0, 0, "R9");
    cmd(0, 1, 0, 1, 0, "R9");
    nops(3, "R9");
    // R8: self refresh entry and exit
    cyc(1, 0, 0, 0, 0, 1, 0, 0, "R8");
    cyc(0, 0, 1, 0, 0, 0, 0, 0, "R8");
    cyc(0, 0, 1, 0, 0, 0, 0, 0, "R8");
    cyc(0, 1, 0, 1, 1, 1, 0, 0, "R8");
    // R10: malformed edges and mismatched CKE
    cyc(1, 0, 0, 0, 1, 1, 0, 0, "R10");
    cyc(0, 1, 0, 1, 1, 1, 0, 0, "R10");
    cyc(0, 0, 1, 1, 1, 1, 0, 0, "R10");
    cyc(1, 0, 1, 1, 1, 1, 0, 0, "R10");
    cmd(0, 1, 1, 0, 0, "R10");
    cyc(0, 1, 1, 1, 1, 1, 0, 0, "R10");
    cyc(1, 0, 0, 0, 0, 1, 0, 0, "R10");
    cyc(0, 1, 0, 0, 1, 1, 0, 0, "R10");
    cyc(0, 1, 1, 0, 0, 0, 0, 0, "R10");
    // R12: burst 8, window 4+3=7
    cfg_bl = 2'd2;
    cmd(0, 1, 1, 0, 3, "R12");
    cmd(1, 0, 1, 1, 3, "R12");
    nops(5, "R12");
    cmd(0, 1, 1, 0, 3, "R12");
    cmd(0, 1, 1, 0, 3, "R12");
    // R12: burst 2, window 1+3=4
    cfg_bl = 2'd0;
    cmd(1, 0, 1, 1, 3, "R12");
    nops(2, "R12");
    cmd(0, 1, 1, 0, 3, "R12");
    cmd(0, 1, 1, 0, 3, "R12");
    // R12: value 3 behaves as burst 8 in write window 4+1+2+3=10
    cfg_bl = 2'd3;
    cmd(1, 0, 0, 1, 3, "R12");
    nops(8, "R12");
    cmd(0, 1, 1, 0, 3, "R12");
    cmd(0, 1, 1, 0, 3, "R12");

    // R1/R11: pseudo-random pins compared against the model
    cfg_bl = 2'd1;
    pk = 1;
    for (int i = 0; i < 3000; i++) begin
      bit kn;
      int rv;
      rv = $urandom;
      kn = (rv % 12) != 0;
      cyc(pk, kn, (rv >> 4) % 5 == 0, rv[8], rv[9], rv[10], rv[11], (rv >> 12) % 4, "R1");
      pk = kn;
    end
    summary();
  end

endmodule